// File: doc/BRIEF.md
# Memory Contention Wait-State Generator

This block sits beside an 8-bit CPU whose memory is shared with a video controller. On every machine-cycle memory or I/O request it works out the target of the access (internal RAM, ROM, external RAM, or an I/O port) and the current display state. From these it decides how many wait T-states the CPU must spend before the access may proceed. One clock of the block is one CPU T-state.

A free-running 3-bit phase counter sets up two slot grids: a fine grid with a boundary every 4 T-states and a coarse grid with a boundary every 8 T-states. The sync input restarts the counter. A contended access is pushed forward to the next boundary of its grid. Internal RAM uses the coarse grid while the active picture is being drawn or a stripe of the striped display mode is under way. It uses the fine grid over the border and whenever the picture is blanked. The high I/O port range is always on the coarse grid. ROM, external RAM and the low ports never wait.

The CPU samples the active-low wait output. It stays low for exactly the computed number of T-states after the request is accepted. Opcode fetches are presented as ordinary memory requests to the region that holds the code.

Top module: `contention_wait_gen`

## Requirements
- R1: Reset, or `sync`, sets the phase counter to 0 at the next clock edge; after that it counts up by one per clock, wrapping modulo 8. After reset `wait_n` is 1.
- R2: Target decode: `acc_io`=1 selects an I/O port, given by `acc_addr[7:0]`. Otherwise the target is ROM if `rom_low_en`=1 and `acc_addr[15:14]`=00, else external RAM if `ext_high_en`=1 and `acc_addr[15]`=1, else internal RAM.
- R3: ROM and external RAM accesses get zero wait states.
- R4: For an internal RAM access over the border (screen enabled, `raster_on_screen`=0, no active stripe), the wait count is (4 − p mod 4) mod 4. Here p is the phase during the clock in which `acc_start` is sampled.
- R5: For an internal RAM access with the screen enabled and `raster_on_screen`=1, the wait count is (8 − p) mod 8.
- R6: With `screen_en`=0, internal RAM always uses the rule of R4, whatever the raster and stripe inputs are.
- R7: With `stripe_mode`=1 and `in_stripe`=1 and the screen enabled, internal RAM uses the rule of R5 even over the border. `in_stripe` has no effect while `stripe_mode`=0.
- R8: An I/O access to a port at 0xF8 or above waits (8 − p) mod 8 in any display state. Ports below 0xF8 wait zero.
- R9: `wait_n` is low for exactly N consecutive clocks, starting the clock after the edge that samples `acc_start`. When N=0, `wait_n` never goes low.
- R10: `acc_start` asserted while `wait_n` is low is ignored: the current wait run keeps its length, and no further wait run follows it.
- R11: Repeated accesses to the high port range take the same total time whatever the idle gap (up to 7 T-states) between them: each access re-aligns to the 8 T-state grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Restarts the phase counter at 0 |
| acc_start | input | 1 | First T-state of a memory or I/O request |
| acc_io | input | 1 | 1 = I/O request, 0 = memory request |
| acc_addr | input | 16 | Request address; low byte is the port number for I/O |
| rom_low_en | input | 1 | Lowest quarter of the address space maps to ROM |
| ext_high_en | input | 1 | Upper half of the address space maps to external RAM |
| screen_en | input | 1 | Display fetches enabled |
| raster_on_screen | input | 1 | Raster is over the active picture area |
| stripe_mode | input | 1 | Display mode with extra contention stripes selected |
| in_stripe | input | 1 | Raster is inside one of those stripes |
| wait_n | output | 1 | Active-low wait to the CPU |

## Verification
A request sampled at one clock edge shows its first wait T-state in the clock after that edge. The wait run ends N clocks later, so the bench drives `acc_start` on a falling edge. From the next falling edge onward it counts the low samples of `wait_n`. The expected N uses a phase that the bench keeps itself: it resets the count on reset and on sync and increments it on every rising edge, reading it in the cycle the request is presented. The R11 totals are cycle counts measured from the first request to the release of the last one.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

    localparam int unsigned PH_W     = 3;
    localparam int unsigned FINE_LOG = PH_W - 1;

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [2:0] {
        TGT_INT_RAM,
        TGT_ROM,
        TGT_EXT_RAM,
        TGT_IO_SLOW,
        TGT_IO_FAST
    } target_e;

    typedef enum logic [1:0] {
        GRID_NONE,
        GRID_FINE,
        GRID_COARSE
    } grid_e;

    typedef struct packed {
        target_e tgt;
        grid_e   grid;
    } acc_class_t;

    // Distance from phase p forward to the next boundary of grid g.
    function automatic phase_t slot_waits(grid_e g, phase_t p);
        phase_t mask;
        case (g)
            GRID_COARSE: mask = '1;
            GRID_FINE:   mask = phase_t'((1 << FINE_LOG) - 1);
            default:     mask = '0;
        endcase
        return phase_t'((phase_t'(0) - p) & mask);
    endfunction

endpackage

// File: rtl/cwg_phase_ctr.sv
module cwg_phase_ctr
    import cwg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync,
    output phase_t phase
);
    always_ff @(posedge clk) begin
        if (rst || sync) phase <= '0;
        else             phase <= phase + phase_t'(1);
    end
endmodule

// File: rtl/cwg_classify.sv
module cwg_classify
    import cwg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PORT_W    = 8,
    parameter logic [7:0]  ASIC_BASE = 8'hF8
) (
    input  logic              acc_io,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              rom_low_en,
    input  logic              ext_high_en,
    input  logic              screen_en,
    input  logic              raster_on_screen,
    input  logic              stripe_mode,
    input  logic              in_stripe,
    output acc_class_t        cls
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic [PORT_W-1:0] port;
    logic              in_rom_window;
    logic              in_ext_window;
    logic              coarse_video;

    assign port          = acc_addr[PORT_W-1:0];
    assign in_rom_window = (acc_addr[TOP -: 2] == 2'b00);
    assign in_ext_window = acc_addr[TOP];
    assign coarse_video  = raster_on_screen || (stripe_mode && in_stripe);

    always_comb begin
        if (acc_io) begin
            cls.tgt = (port >= PORT_W'(ASIC_BASE)) ? TGT_IO_SLOW : TGT_IO_FAST;
        end else if (rom_low_en && in_rom_window) begin
            cls.tgt = TGT_ROM;
        end else if (ext_high_en && in_ext_window) begin
            cls.tgt = TGT_EXT_RAM;
        end else begin
            cls.tgt = TGT_INT_RAM;
        end

        case (cls.tgt)
            TGT_IO_SLOW: cls.grid = GRID_COARSE;
            TGT_INT_RAM: begin
                if (!screen_en)        cls.grid = GRID_FINE;
                else if (coarse_video) cls.grid = GRID_COARSE;
                else                   cls.grid = GRID_FINE;
            end
            default:     cls.grid = GRID_NONE;
        endcase
    end
endmodule

// File: rtl/cwg_wait_timer.sv
module cwg_wait_timer
    import cwg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acc_start,
    input  grid_e  grid,
    input  phase_t phase,
    output logic   wait_n
);
    phase_t remain;

    assign wait_n = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - phase_t'(1);
        end else if (acc_start) begin
            remain <= slot_waits(grid, phase);
        end
    end
endmodule

// File: rtl/contention_wait_gen.sv
module contention_wait_gen
    import cwg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PORT_W    = 8,
    parameter logic [7:0]  ASIC_BASE = 8'hF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync,
    input  logic              acc_start,
    input  logic              acc_io,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              rom_low_en,
    input  logic              ext_high_en,
    input  logic              screen_en,
    input  logic              raster_on_screen,
    input  logic              stripe_mode,
    input  logic              in_stripe,
    output logic              wait_n
);
    phase_t     phase;
    acc_class_t cls;

    cwg_phase_ctr u_phase (
        .clk   (clk),
        .rst   (rst),
        .sync  (sync),
        .phase (phase)
    );

    cwg_classify #(
        .ADDR_W    (ADDR_W),
        .PORT_W    (PORT_W),
        .ASIC_BASE (ASIC_BASE)
    ) u_class (
        .acc_io           (acc_io),
        .acc_addr         (acc_addr),
        .rom_low_en       (rom_low_en),
        .ext_high_en      (ext_high_en),
        .screen_en        (screen_en),
        .raster_on_screen (raster_on_screen),
        .stripe_mode      (stripe_mode),
        .in_stripe        (in_stripe),
        .cls              (cls)
    );

    cwg_wait_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .acc_start (acc_start),
        .grid      (cls.grid),
        .phase     (phase),
        .wait_n    (wait_n)
    );
endmodule

// File: rtl/cwg_checker.sv
module cwg_checker
    import cwg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sync,
    input logic       acc_start,
    input logic       wait_n,
    input phase_t     phase,
    input acc_class_t cls
);
    logic       sync_seen;
    logic       coarse_run;
    logic [3:0] low_run;
    logic       accept;

    assign accept = acc_start && wait_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_seen  <= 1'b0;
            coarse_run <= 1'b0;
            low_run    <= '0;
        end else begin
            if (accept)    sync_seen <= sync;
            else if (sync) sync_seen <= 1'b1;
            if (accept) coarse_run <= (cls.grid == GRID_COARSE);
            low_run <= wait_n ? 4'd0 : low_run + 4'd1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> wait_n);

    assert_free_targets_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && (cls.tgt == TGT_ROM || cls.tgt == TGT_EXT_RAM || cls.tgt == TGT_IO_FAST))
        |=> wait_n);

    assert_fine_align_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(wait_n) && !sync_seen && !$past(sync)) |-> (phase[1:0] == 2'd1));

    assert_coarse_align_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(wait_n) && coarse_run && !sync_seen && !$past(sync)) |-> (phase == phase_t'(1)));

    assert_run_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        low_run <= 4'd7);

    assert_fall_needs_request_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_n) |-> $past(acc_start));
endmodule

bind contention_wait_gen cwg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync      (sync),
    .acc_start (acc_start),
    .wait_n    (wait_n),
    .phase     (phase),
    .cls       (cls)
);

// File: tb/tb_contention_wait_gen.sv
module tb_contention_wait_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        acc_start = 1'b0;
    logic        acc_io = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        rom_low_en = 1'b0;
    logic        ext_high_en = 1'b0;
    logic        screen_en = 1'b0;
    logic        raster_on_screen = 1'b0;
    logic        stripe_mode = 1'b0;
    logic        in_stripe = 1'b0;
    logic        wait_n;

    int checks = 0;
    int fails  = 0;
    int tb_ph  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    contention_wait_gen dut (
        .clk(clk), .rst(rst), .sync(sync), .acc_start(acc_start), .acc_io(acc_io),
        .acc_addr(acc_addr), .rom_low_en(rom_low_en), .ext_high_en(ext_high_en),
        .screen_en(screen_en), .raster_on_screen(raster_on_screen),
        .stripe_mode(stripe_mode), .in_stripe(in_stripe), .wait_n(wait_n)
    );

    // Phase kept by the bench from R1.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || sync) tb_ph <= 0;
        else             tb_ph <= (tb_ph + 1) % 8;
    end

    function automatic int fine_w(int p);
        return (4 - (p % 4)) % 4;
    endfunction

    function automatic int coarse_w(int p);
        return (8 - p) % 8;
    endfunction

    function automatic int exp_waits(int p);
        if (acc_io) return (acc_addr[7:0] >= 8'hF8) ? coarse_w(p) : 0;
        if (rom_low_en && acc_addr[15:14] == 2'b00) return 0;
        if (ext_high_en && acc_addr[15]) return 0;
        if (!screen_en) return fine_w(p);
        if (raster_on_screen || (stripe_mode && in_stripe)) return coarse_w(p);
        return fine_w(p);
    endfunction

    function automatic string req_tag();
        if (acc_io) return "R8";
        if (rom_low_en && acc_addr[15:14] == 2'b00) return "R3";
        if (ext_high_en && acc_addr[15]) return "R3";
        if (!screen_en) return "R6";
        if (raster_on_screen) return "R5";
        if (stripe_mode && in_stripe) return "R7";
        return "R4";
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (time %0t)", tag, got, exp, $time);
        end
    endtask

    // Present one request at a falling edge; return the measured low run.
    task automatic access(output int got, output int expn);
        expn = exp_waits(tb_ph);
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        got = 0;
        while (wait_n == 1'b0 && got < 15) begin
            got++;
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mem(logic [15:0] a, bit rom, bit ext, bit scr, bit ras, bit sm, bit st);
        acc_io = 1'b0; acc_addr = a; rom_low_en = rom; ext_high_en = ext;
        screen_en = scr; raster_on_screen = ras; stripe_mode = sm; in_stripe = st;
    endtask

    task automatic set_io(logic [7:0] port);
        acc_io = 1'b1; acc_addr = {8'h00, port};
    endtask

    task automatic align_to(int ph);
        while (tb_ph != ph) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int got, expn, t0, tot_a, tot_b;
        void'($urandom(32'd7719));
        idle(3);
        check("R1 wait_n in reset", int'(wait_n), 1);
        rst = 1'b0;
        idle(1);
        check("R1 wait_n after reset", int'(wait_n), 1);

        // R1: sync restarts phase; access right after sees p=0 then p=1.
        set_mem(16'h4000, 0, 0, 1, 1, 0, 0);
        idle(2);
        sync = 1'b1; idle(1); sync = 1'b0;
        access(got, expn);
        check("R1 sync then coarse access p0", got, 0);
        idle(3);
        sync = 1'b1; idle(1); sync = 1'b0;
        idle(1);
        access(got, expn);
        check("R1 sync then coarse access p1", got, 7);

        // R2/R3 directed decode corners.
        set_mem(16'h3FFF, 1, 1, 1, 1, 0, 0); align_to(1); access(got, expn);
        check("R2 R3 rom window top", got, 0);
        set_mem(16'h3FFF, 0, 1, 1, 1, 0, 0); align_to(1); access(got, expn);
        check("R2 rom disabled is internal", got, 7);
        set_mem(16'h8000, 0, 1, 1, 1, 0, 0); align_to(3); access(got, expn);
        check("R2 R3 external window", got, 0);
        set_mem(16'h7FFF, 0, 1, 1, 1, 0, 0); align_to(3); access(got, expn);
        check("R2 below external window", got, 5);

        // R4..R7 directed.
        set_mem(16'h4000, 0, 0, 1, 0, 0, 0); align_to(1); access(got, expn);
        check("R4 border p1", got, 3);
        set_mem(16'h4000, 0, 0, 0, 1, 1, 1); align_to(5); access(got, expn);
        check("R6 screen off p5", got, 3);
        set_mem(16'h4000, 0, 0, 1, 0, 1, 1); align_to(2); access(got, expn);
        check("R7 stripe p2", got, 6);
        set_mem(16'h4000, 0, 0, 1, 0, 0, 1); align_to(2); access(got, expn);
        check("R7 stripe ignored without mode", got, 2);

        // R8 port boundary.
        set_io(8'hF7); align_to(1); access(got, expn);
        check("R8 port F7", got, 0);
        set_io(8'hF8); align_to(1); access(got, expn);
        check("R8 port F8", got, 7);

        // R10: request during a wait is ignored.
        set_mem(16'h4000, 0, 0, 1, 1, 0, 0); align_to(1);
        acc_start = 1'b1; @(negedge clk);
        got = 0;
        while (wait_n == 1'b0 && got < 15) begin
            acc_start = (got == 2);
            got++;
            @(negedge clk);
        end
        acc_start = 1'b0;
        check("R10 run length unchanged", got, 7);
        expn = 0;
        for (int i = 0; i < 10; i++) begin
            if (wait_n == 1'b0) expn++;
            @(negedge clk);
        end
        check("R10 no follow-on run", expn, 0);

        // R11 pair with gap 3 versus gap 7.
        set_io(8'hF8);
        align_to(0); t0 = cyc; access(got, expn); idle(3); access(got, expn); tot_a = cyc - t0;
        align_to(0); t0 = cyc; access(got, expn); idle(7); access(got, expn); tot_b = cyc - t0;
        check("R11 pair total gap3", tot_a, 9);
        check("R11 pair totals equal", tot_a, tot_b);
        // R11 block of four with gap 2 versus gap 6.
        align_to(0); t0 = cyc; access(got, expn);
        for (int i = 0; i < 3; i++) begin idle(2); access(got, expn); end
        tot_a = cyc - t0;
        align_to(0); t0 = cyc; access(got, expn);
        for (int i = 0; i < 3; i++) begin idle(6); access(got, expn); end
        tot_b = cyc - t0;
        check("R11 block total", tot_a, 25);
        check("R11 block totals equal", tot_a, tot_b);

        // Random sweep over targets, display states and phases (R2..R9).
        for (int n = 0; n < 600; n++) begin
            idle($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) begin
                set_io(($urandom_range(0, 1) == 1) ? 8'(8'hF8 + $urandom_range(0, 7))
                                                  : 8'($urandom_range(0, 255)));
            end else begin
                set_mem(16'($urandom_range(0, 65535)), bit'($urandom_range(0, 1)),
                        bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                        bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                        bit'($urandom_range(0, 1)));
            end
            begin
                string tg;
                tg = req_tag();
                access(got, expn);
                check({tg, " R9 random run length"}, got, expn);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule